// File: doc/BRIEF.md
# Variable-Rate QPSK Pulse-Shaping Interpolator

This block turns a stream of QPSK dibits into root-raised-cosine shaped baseband I and Q samples. The sample clock is fixed and one sample pair leaves the block on every clock edge. The symbol rate is set separately by a 32-bit tuning word. A phase accumulator adds the active tuning word once per clock. Each carry out of its top bit marks a symbol boundary, and at that point the block takes one dibit from the upstream source. The tuning word resolution is the sample clock divided by 2^32, which is about 0.023 Hz at 100 MHz. Symbol rates from about 1 to 45 Msymbol/s are therefore reachable from one fixed clock.

The fraction of the current symbol period that has elapsed is held in the top phase bits. Those bits pick one of many finely spaced coefficient phases of a tabulated root-raised-cosine impulse response. That coefficient phase is applied to the last six symbols, so the block works as an interpolator with a continuously variable, non-integer ratio. If the source has no dibit ready at a symbol boundary, a silent symbol is inserted in its place and a one-cycle flag reports the gap.

Top module: `vrate_qpsk_shaper`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, i_out and q_out are 0 and sym_ready and starved are low.
- R2: A 32-bit phase accumulator adds the active tuning word on every clock. sym_ready is high in exactly those cycles where accumulator plus active word carries out of bit 31. Only in such a cycle does the symbol history shift, by one position.
- R3: Bit 1 of sym_dibit drives the I symbol and bit 0 drives the Q symbol. A 0 bit gives +1 and a 1 bit gives -1.
- R4: One cycle after a given state, i_out equals the sum over k = 0..5 of s_k·c(p + 512·k). Here p is accumulator bits [31:23], s_0 is the newest I symbol, and c(n) = round(S·h(n/512 − 3)), with h the root-raised-cosine pulse of roll-off 0.35 and S = 32767/1.25. q_out is formed the same way from the Q symbols. When the whole history is zero, both outputs are 0.
- R5: tune_word is sampled only in a cycle where sym_ready is high, or while the active word is zero. A change at any other time does not alter the length of the symbol in progress.
- R6: A tuning word above 2^31 is replaced by 2^31, so sym_ready is never high in two consecutive cycles.
- R7: If sym_valid is low in a cycle where sym_ready is high, a 0 symbol enters both the I and Q histories, and starved is high in that same cycle. starved is low in every other cycle.
- R8: With a constant tuning word W, the number of sym_ready cycles within N clocks is within one of W·N/2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tune_word | input | 32 | Symbol-rate tuning word, as a fraction of 2^32 per clock |
| sym_dibit | input | 2 | Dibit to send; bit 1 is I, bit 0 is Q |
| sym_valid | input | 1 | sym_dibit holds a symbol |
| sym_ready | output | 1 | Symbol boundary; the dibit is taken this cycle |
| starved | output | 1 | Boundary reached with no dibit available |
| i_out | output | 20 | Signed shaped I sample |
| q_out | output | 20 | Signed shaped Q sample |

## Verification
A counting dibit sequence at roughly five samples per symbol shows whether the bit-to-axis and sign mapping is right, because all four constellation points pass through every filter tap. A pseudo-random sequence at an irregular tuning word drives the fractional phase across the whole coefficient table, which would expose a wrong tap order or phase slice. A reset-aligned rate change tells apart a word that is taken at the boundary from one that is taken at once. A source gap, a saturated word and a long run at constant rate check the inserted silence, the clamp and the average symbol count.

// File: rtl/vrq_pkg.sv
package vrq_pkg;

  localparam real PI_R = 3.14159265358979;

  function automatic real vabs(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  // root-raised-cosine pulse at t symbol periods, roll-off b
  function automatic real rrc_shape(input real t, input real b);
    real num;
    real den;
    real edge_t;
    edge_t = 1.0 / (4.0 * b);
    if (vabs(t) < 1.0e-9)
      return 1.0 - b + 4.0 * b / PI_R;
    if (vabs(vabs(t) - edge_t) < 1.0e-9)
      return (b / $sqrt(2.0)) * ((1.0 + 2.0 / PI_R) * $sin(PI_R / (4.0 * b))
                               + (1.0 - 2.0 / PI_R) * $cos(PI_R / (4.0 * b)));
    num = $sin(PI_R * t * (1.0 - b)) + 4.0 * b * t * $cos(PI_R * t * (1.0 + b));
    den = PI_R * t * (1.0 - (4.0 * b * t) * (4.0 * b * t));
    return num / den;
  endfunction

  // integer coefficient for table entry idx of a table with nph phases per symbol
  function automatic int coef_at(input int idx, input int nph, input int ntaps, input int cw);
    real t;
    real x;
    real scale;
    scale = (real'((1 << (cw - 1)) - 1)) / 1.25;
    t = real'(idx) / real'(nph) - real'(ntaps) / 2.0;
    x = rrc_shape(t, 0.35) * scale;
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

  // dibit bit to antipodal level: 0 -> +1, 1 -> -1 (two-bit signed code)
  function automatic logic [1:0] level_of(input logic b);
    return b ? 2'b11 : 2'b01;
  endfunction

  // weight a coefficient by a level code (+1, -1 or 0)
  function automatic logic signed [31:0] weigh(input logic [1:0] s, input logic signed [31:0] c);
    case (s)
      2'b01:   return c;
      2'b11:   return -c;
      default: return 32'sd0;
    endcase
  endfunction

endpackage

// File: rtl/vrq_nco.sv
module vrq_nco #(
  parameter int PHASE_W = 32,
  parameter int SEL_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] tune_word,
  output logic               wrap,
  output logic [SEL_W-1:0]   phase_sel
);
  localparam logic [PHASE_W-1:0] WORD_MAX = {1'b1, {(PHASE_W-1){1'b0}}};

  function automatic logic [PHASE_W-1:0] clamp_word(input logic [PHASE_W-1:0] w);
    return (w > WORD_MAX) ? WORD_MAX : w;
  endfunction

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] word_q;
  logic [PHASE_W:0]   sum;
  logic               load_word;

  assign sum       = {1'b0, acc_q} + {1'b0, word_q};
  assign wrap      = sum[PHASE_W];
  assign load_word = wrap || (word_q == '0);
  assign phase_sel = acc_q[PHASE_W-1 -: SEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      word_q <= '0;
    end else begin
      acc_q <= sum[PHASE_W-1:0];
      if (load_word) word_q <= clamp_word(tune_word);
    end
  end

  // R5: the active word holds between boundaries once loaded
  p_word_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && word_q != '0) |=> $stable(word_q));

  // R6: boundaries are never adjacent
  p_no_adjacent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !wrap);

endmodule

// File: rtl/vrq_history.sv
module vrq_history #(
  parameter int NTAPS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift,
  input  logic                  take,
  input  logic [1:0]            dibit,
  output logic [NTAPS-1:0][1:0] hist_i,
  output logic [NTAPS-1:0][1:0] hist_q
);
  import vrq_pkg::*;

  logic [1:0] new_i;
  logic [1:0] new_q;

  assign new_i = take ? level_of(dibit[1]) : 2'b00;
  assign new_q = take ? level_of(dibit[0]) : 2'b00;

  for (genvar k = 0; k < NTAPS; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist_i[k] <= 2'b00;
        hist_q[k] <= 2'b00;
      end else if (shift) begin
        if (k == 0) begin
          hist_i[k] <= new_i;
          hist_q[k] <= new_q;
        end else begin
          hist_i[k] <= hist_i[k-1];
          hist_q[k] <= hist_q[k-1];
        end
      end
    end
  end

  // R2: history moves only on a symbol boundary
  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> ($stable(hist_i) && $stable(hist_q)));

  // R7: a boundary without data leaves a silent newest symbol
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !take) |=> (hist_i[0] == 2'b00 && hist_q[0] == 2'b00));

endmodule

// File: rtl/vrq_shaper.sv
module vrq_shaper #(
  parameter int NTAPS  = 6,
  parameter int SEL_W  = 9,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEL_W-1:0]         phase_sel,
  input  logic [NTAPS-1:0][1:0]    hist_i,
  input  logic [NTAPS-1:0][1:0]    hist_q,
  output logic signed [OUT_W-1:0]  i_out,
  output logic signed [OUT_W-1:0]  q_out
);
  import vrq_pkg::*;

  localparam int NPH = 1 << SEL_W;

  logic signed [COEF_W-1:0] tap_c [NTAPS];
  logic signed [31:0]       acc_i;
  logic signed [31:0]       acc_q;
  logic                     hist_silent;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [COEF_W-1:0] rom [NPH];
    initial begin
      for (int p = 0; p < NPH; p++)
        rom[p] = COEF_W'(coef_at(k * NPH + p, NPH, NTAPS, COEF_W));
    end
    assign tap_c[k] = rom[phase_sel];
  end

  always_comb begin
    acc_i = 32'sd0;
    acc_q = 32'sd0;
    for (int k = 0; k < NTAPS; k++) begin
      acc_i = acc_i + weigh(hist_i[k], 32'(tap_c[k]));
      acc_q = acc_q + weigh(hist_q[k], 32'(tap_c[k]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_out <= '0;
      q_out <= '0;
    end else begin
      i_out <= OUT_W'(acc_i);
      q_out <= OUT_W'(acc_q);
    end
  end

  assign hist_silent = (hist_i == '0) && (hist_q == '0);

  // R4: an all-silent history produces silent outputs
  p_silent_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hist_silent |=> (i_out == '0 && q_out == '0));

endmodule

// File: rtl/vrate_qpsk_shaper.sv
module vrate_qpsk_shaper #(
  parameter int PHASE_W = 32,
  parameter int SEL_W   = 9,
  parameter int NTAPS   = 6,
  parameter int COEF_W  = 16,
  localparam int OUT_W  = COEF_W + $clog2(NTAPS) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PHASE_W-1:0]      tune_word,
  input  logic [1:0]              sym_dibit,
  input  logic                    sym_valid,
  output logic                    sym_ready,
  output logic                    starved,
  output logic signed [OUT_W-1:0] i_out,
  output logic signed [OUT_W-1:0] q_out
);
  logic                  boundary;
  logic                  take;
  logic [SEL_W-1:0]      phase_sel;
  logic [NTAPS-1:0][1:0] hist_i;
  logic [NTAPS-1:0][1:0] hist_q;

  vrq_nco #(.PHASE_W(PHASE_W), .SEL_W(SEL_W)) u_nco (
    .clk       (clk),
    .rst_n     (rst_n),
    .tune_word (tune_word),
    .wrap      (boundary),
    .phase_sel (phase_sel)
  );

  assign take      = boundary && sym_valid;
  assign sym_ready = boundary;
  assign starved   = boundary && !sym_valid;

  vrq_history #(.NTAPS(NTAPS)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (boundary),
    .take   (take),
    .dibit  (sym_dibit),
    .hist_i (hist_i),
    .hist_q (hist_q)
  );

  vrq_shaper #(.NTAPS(NTAPS), .SEL_W(SEL_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_sel (phase_sel),
    .hist_i    (hist_i),
    .hist_q    (hist_q),
    .i_out     (i_out),
    .q_out     (q_out)
  );

  // R7: the starvation flag only rises on a symbol boundary
  p_starve_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    starved |-> (sym_ready && !sym_valid));

endmodule

// File: tb/vrate_qpsk_shaper_test.sv
module vrate_qpsk_shaper_test;
  localparam int  NPH   = 512;
  localparam int  NT    = 6;
  localparam int  TOL   = 8;
  localparam longint unsigned FULL = 64'h1_0000_0000;
  localparam longint unsigned CAP  = 64'h8000_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [31:0] tune_word;
  logic [1:0]  sym_dibit;
  logic        sym_valid;
  wire         sym_ready;
  wire         starved;
  wire signed [19:0] i_out;
  wire signed [19:0] q_out;

  vrate_qpsk_shaper uut (
    .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .sym_dibit(sym_dibit),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .starved(starved),
    .i_out(i_out), .q_out(q_out)
  );

  int checks = 0;
  int bad    = 0;
  string tag = "R1";
  bit compare_on = 0;
  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // independent coefficient table
  int bc [NT*NPH];
  function automatic real pulse(input real t);
    real a; real r; real z;
    r = 0.35;
    a = (t < 0.0) ? -t : t;
    if (a < 1.0e-9) return (1.0 - r) + 4.0 * r / 3.14159265358979;
    z = 4.0 * r * t;
    if (((z * z - 1.0) < 1.0e-9) && ((1.0 - z * z) < 1.0e-9))
      return r / $sqrt(2.0) * ((1.0 + 2.0 / 3.14159265358979) * $sin(3.14159265358979 / (4.0 * r))
                             + (1.0 - 2.0 / 3.14159265358979) * $cos(3.14159265358979 / (4.0 * r)));
    return ($sin(3.14159265358979 * t * (1.0 - r)) + z * $cos(3.14159265358979 * t * (1.0 + r)))
           / (3.14159265358979 * t * (1.0 - z * z));
  endfunction
  initial begin
    for (int n = 0; n < NT*NPH; n++)
      bc[n] = int'($floor(pulse(real'(n) / 512.0 - 3.0) * (32767.0 / 1.25) + 0.5));
  end

  // behavioural model
  longint unsigned m_acc = 0, m_tw = 0;
  int mi[$], mq[$];
  int exp_i = 0, exp_q = 0;
  bit took = 0;

  function automatic int lvl(input logic b);
    return b ? -1 : 1;
  endfunction

  always @(posedge clk) begin
    longint unsigned s;
    int ph;
    bit w;
    if (!rst_n) begin
      m_acc = 0; m_tw = 0; exp_i = 0; exp_q = 0; took = 0;
      mi = {0,0,0,0,0,0}; mq = {0,0,0,0,0,0};
    end else begin
      ph = int'(m_acc >> 23);
      exp_i = 0; exp_q = 0;
      for (int k = 0; k < NT; k++) begin
        exp_i += mi[k] * bc[k*NPH + ph];
        exp_q += mq[k] * bc[k*NPH + ph];
      end
      s = m_acc + m_tw;
      w = (s >= FULL);
      took = w && sym_valid;
      if (w || m_tw == 0) m_tw = (tune_word > CAP) ? CAP : longint'(tune_word);
      m_acc = s % FULL;
      if (w) begin
        mi.push_front(took ? lvl(sym_dibit[1]) : 0);
        mq.push_front(took ? lvl(sym_dibit[0]) : 0);
        void'(mi.pop_back());
        void'(mq.pop_back());
      end
    end
  end

  // dibit source
  always @(posedge clk) begin
    #2;
    if (took) begin
      if (mode == 0) sym_dibit = sym_dibit + 2'd1;
      else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sym_dibit = lfsr[1:0];
      end
    end
  end

  // per-cycle comparison (R2 boundary, R3/R4 samples, R7 flag)
  always @(negedge clk) begin
    bit pw;
    if (rst_n && compare_on) begin
      pw = ((m_acc + m_tw) >= FULL);
      chk(sym_ready == pw, tag, "sym_ready", sym_ready, pw);
      chk(starved == (pw && !sym_valid), tag, "starved", starved, pw && !sym_valid);
      chk((i_out - exp_i <= TOL) && (exp_i - i_out <= TOL), tag, "i_out", i_out, exp_i);
      chk((q_out - exp_q <= TOL) && (exp_q - q_out <= TOL), tag, "q_out", q_out, exp_q);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic gap_to_ready(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sym_ready && n < 1000);
  endtask

  initial begin
    int n;
    int cnt;
    real want;
    rst_n = 0; tune_word = 0; sym_valid = 0; sym_dibit = 0;
    cycles(3);
    @(negedge clk);
    tag = "R1";
    chk(i_out == 0, "R1", "i_out in reset", i_out, 0);
    chk(q_out == 0, "R1", "q_out in reset", q_out, 0);
    chk(sym_ready == 0, "R1", "sym_ready in reset", sym_ready, 0);
    chk(starved == 0, "R1", "starved in reset", starved, 0);
    @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    chk(i_out == 0 && q_out == 0, "R1", "outputs after reset", i_out, 0);
    compare_on = 1;

    // R3 R4: counting dibits, about five samples per symbol
    tag = "R3/R4 counting"; tune_word = 32'h3333_3333; sym_valid = 1; mode = 0;
    cycles(600);
    // R4 R2: pseudo-random dibits, irregular word
    tag = "R4/R2 random"; mode = 1; tune_word = 32'h1A2B_3C4D;
    cycles(1500);

    // R5: reset-aligned rate change taken only at the boundary
    rst_n = 0; tune_word = 32'h4000_0000; cycles(2); rst_n = 1;
    tag = "R5";
    cycles(9);
    @(negedge clk); while (!sym_ready) @(negedge clk);
    @(posedge clk); #2; tune_word = 32'h1000_0000;
    gap_to_ready(n);
    chk(n == 4, "R5", "symbol length after mid-symbol change", n, 4);
    gap_to_ready(n);
    chk(n == 16, "R5", "symbol length with new word", n, 16);

    // R7: source gap
    tag = "R7"; tune_word = 32'h2000_0000; sym_valid = 0;
    cycles(300);
    @(negedge clk);
    chk(i_out == 0, "R7", "i_out after starvation", i_out, 0);
    chk(q_out == 0, "R7", "q_out after starvation", q_out, 0);
    @(posedge clk); #2; sym_valid = 1;
    cycles(200);

    // R6: saturated word
    tag = "R6"; tune_word = 32'hFFFF_FFFF;
    cycles(40);
    cnt = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (sym_ready) cnt++;
    end
    chk(cnt == 20, "R6", "boundaries in 40 cycles at clamp", cnt, 20);

    // R8: long-run average
    tag = "R8"; tune_word = 32'h0ABC_DEF1;
    @(negedge clk); while (!sym_ready) @(negedge clk);
    @(negedge clk); while (!sym_ready) @(negedge clk);
    cnt = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (sym_ready) cnt++;
    end
    want = real'(32'h0ABC_DEF1) * 20000.0 / 4294967296.0;
    chk((real'(cnt) - want <= 1.0) && (want - real'(cnt) <= 1.0), "R8",
        "symbols in 20000 cycles", cnt, longint'(want));

    compare_on = 0;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #1000000;
    checks++; bad++;
    $display("FAIL watchdog expired in %s actual=1 expected=0", tag);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule